// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures the frequency of an intermediate-frequency signal by counting how many IF edge pulses arrive inside a timed gate window. The edge pulses reach the counter directly, with no prescaler. One counter serves both AM and FM IF measurement. The window length is a whole number of ticks from a 1 kHz reference time base, and a 2-bit field picks one of four lengths: 4, 8, 32 or 64 ms. When the window closes, the running count is copied into a shadow register and a done flag is raised.

A controller collects the result over a three-wire serial port made of an enable, a clock and a data line. Raising the enable loads the shadow value into a shift register. Each rising serial clock then moves the next bit onto the data line, most significant bit first. The serial path runs apart from the measuring path, so a controller may read out an older result while a new gate is open. If the count would pass the largest value the counter can hold, it stops at that value and a saturation flag is stored with the result.

Top module: `if_gate_counter`

## Requirements
- R1: While reset is asserted, and directly after it, busy, done, sat and ser_dout are all 0.
- R2: A start pulse seen while busy is 0 raises busy at the next clock edge. A start pulse seen while busy is 1 has no effect: it neither restarts the window nor clears the count.
- R3: The period code is sampled when a start is accepted. Code 0 gives a window of 4 reference ticks, code 1 gives 8, code 2 gives 32 and code 3 gives 64. Only ticks that arrive while busy is 1 are counted, and busy falls at the clock edge of the last tick.
- R4: The count is cleared when a start is accepted. It then rises by one for each clock cycle in which busy is 1 and if_pulse is 1. Pulses that arrive while busy is 0 are not counted.
- R5: When the count reaches 2^CNT_W−1 it stays there, and sat reads 1 for that stored result.
- R6: done rises one clock edge after busy falls. It stays at 1 until a rising edge of ser_en. If a new result is stored in the same cycle as that rising edge, done stays at 1.
- R7: A rising edge of ser_en loads the stored result, and from the next cycle ser_dout shows its most significant bit. Each rising edge of ser_clk while ser_en is 1 moves the next lower bit onto ser_dout. While ser_en is 0, ser_dout is 0.
- R8: Serial activity during an open window leaves that window's length and its count unchanged.
- R9: Changing period_sel while busy is 1 has no effect on the open window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| if_pulse | input | 1 | One-cycle pulse for each IF edge, synchronous to clk |
| ref_tick | input | 1 | One-cycle pulse at the 1 kHz reference rate |
| period_sel | input | 2 | Gate length code: 0=4, 1=8, 2=32, 3=64 ticks |
| start | input | 1 | Opens a measurement window when idle |
| ser_clk | input | 1 | Serial shift clock, sampled by clk |
| ser_en | input | 1 | Serial read enable, a rising edge loads the result |
| ser_dout | output | 1 | Serial result data, MSB first |
| busy | output | 1 | Gate window open |
| done | output | 1 | New result stored and not yet read |
| sat | output | 1 | Stored result saturated |

## Verification
The bench builds the counter with CNT_W set to 10 and keeps the default tick counts of 4, 8, 32 and 64. A 64-tick window with an IF pulse on every cycle and a tick every 20 cycles then passes 1023 within about 1300 cycles, which brings saturation within a short run. With these values all four gate lengths can also be run back to back, and ticks spaced 5 to 20 cycles apart let the bench start extra measurements and read out results while a window is still open.

// File: rtl/if_gate_pkg.sv
package if_gate_pkg;

    typedef enum logic [1:0] {
        GATE_4T  = 2'd0,
        GATE_8T  = 2'd1,
        GATE_32T = 2'd2,
        GATE_64T = 2'd3
    } gate_code_e;

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/if_gate_timer.sv
module if_gate_timer
    import if_gate_pkg::*;
#(
    parameter int unsigned LEN0 = 4,
    parameter int unsigned LEN1 = 8,
    parameter int unsigned LEN2 = 32,
    parameter int unsigned LEN3 = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       ref_tick,
    input  logic [1:0] period_sel,
    output logic       gate_open,
    output logic       start_ok,
    output logic       gate_end
);
    localparam int unsigned LMAX = max4(LEN0, LEN1, LEN2, LEN3);
    localparam int unsigned TW   = $clog2(LMAX + 1);

    typedef struct packed {
        logic          open;
        logic [TW-1:0] ticks;
        logic [TW-1:0] len;
    } tmr_s;

    tmr_s tmr_d, tmr_q;
    logic [TW-1:0] sel_len;

    always_comb begin
        case (gate_code_e'(period_sel))
            GATE_4T:  sel_len = TW'(LEN0);
            GATE_8T:  sel_len = TW'(LEN1);
            GATE_32T: sel_len = TW'(LEN2);
            default:  sel_len = TW'(LEN3);
        endcase
    end

    always_comb begin
        tmr_d    = tmr_q;
        start_ok = start && !tmr_q.open;
        gate_end = tmr_q.open && ref_tick && (tmr_q.ticks == tmr_q.len - TW'(1));
        if (start_ok) begin
            tmr_d.open  = 1'b1;
            tmr_d.ticks = '0;
            tmr_d.len   = sel_len;
        end else if (gate_end) begin
            tmr_d.open  = 1'b0;
            tmr_d.ticks = '0;
        end else if (tmr_q.open && ref_tick) begin
            tmr_d.ticks = tmr_q.ticks + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign gate_open = tmr_q.open;

endmodule

// File: rtl/if_edge_accum.sv
module if_edge_accum #(
    parameter int unsigned CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             sat
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sat;
    } acc_s;

    acc_s acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clear) begin
            acc_d = '0;
        end else if (inc) begin
            if (acc_q.cnt == CMAX) acc_d.sat = 1'b1;
            else                   acc_d.cnt = acc_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign count = acc_q.cnt;
    assign sat   = acc_q.sat;

endmodule

// File: rtl/if_result_shifter.sv
module if_result_shifter #(
    parameter int unsigned W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_clk,
    input  logic         ser_en,
    input  logic [W-1:0] load_val,
    output logic         rd_start,
    output logic         dout
);
    typedef struct packed {
        logic         en_prev;
        logic         sclk_prev;
        logic [W-1:0] sreg;
    } shf_s;

    shf_s shf_d, shf_q;
    logic sclk_rise;

    always_comb begin
        shf_d           = shf_q;
        rd_start        = ser_en && !shf_q.en_prev;
        sclk_rise       = ser_clk && !shf_q.sclk_prev;
        shf_d.en_prev   = ser_en;
        shf_d.sclk_prev = ser_clk;
        if (rd_start)                 shf_d.sreg = load_val;
        else if (ser_en && sclk_rise) shf_d.sreg = {shf_q.sreg[W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= shf_d;
    end

    assign dout = ser_en && shf_q.sreg[W-1];

endmodule

// File: rtl/if_gate_counter.sv
module if_gate_counter #(
    parameter int unsigned CNT_W = 20,
    parameter int unsigned LEN0  = 4,
    parameter int unsigned LEN1  = 8,
    parameter int unsigned LEN2  = 32,
    parameter int unsigned LEN3  = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       if_pulse,
    input  logic       ref_tick,
    input  logic [1:0] period_sel,
    input  logic       start,
    input  logic       ser_clk,
    input  logic       ser_en,
    output logic       ser_dout,
    output logic       busy,
    output logic       done,
    output logic       sat
);
    typedef struct packed {
        logic             close;
        logic [CNT_W-1:0] res;
        logic             res_sat;
        logic             done;
    } top_s;

    top_s top_d, top_q;

    logic             gate_open, start_ok, gate_end, rd_start;
    logic [CNT_W-1:0] acc_cnt;
    logic             acc_sat;

    if_gate_timer #(
        .LEN0(LEN0), .LEN1(LEN1), .LEN2(LEN2), .LEN3(LEN3)
    ) timer_i (
        .clk(clk), .rst_n(rst_n), .start(start), .ref_tick(ref_tick),
        .period_sel(period_sel), .gate_open(gate_open), .start_ok(start_ok),
        .gate_end(gate_end)
    );

    if_edge_accum #(.CNT_W(CNT_W)) accum_i (
        .clk(clk), .rst_n(rst_n), .clear(start_ok),
        .inc(gate_open && if_pulse), .count(acc_cnt), .sat(acc_sat)
    );

    if_result_shifter #(.W(CNT_W)) shift_i (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_en(ser_en),
        .load_val(top_q.res), .rd_start(rd_start), .dout(ser_dout)
    );

    always_comb begin
        top_d       = top_q;
        top_d.close = gate_end;
        if (rd_start) top_d.done = 1'b0;
        if (top_q.close) begin
            top_d.res     = acc_cnt;
            top_d.res_sat = acc_sat;
            top_d.done    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign busy = gate_open;
    assign done = top_q.done;
    assign sat  = top_q.res_sat;

endmodule

// File: rtl/if_gate_counter_chk.sv
module if_gate_counter_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic ref_tick,
    input logic ser_en,
    input logic ser_dout,
    input logic busy,
    input logic done
);
    logic en_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_prev_q <= 1'b0;
        else        en_prev_q <= ser_en;
    end

    assert_start_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);

    assert_gate_ends_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ref_tick) |=> busy);

    assert_done_after_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |=> done);

    assert_done_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(ser_en && !en_prev_q)) |=> done);

    assert_quiet_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en |-> !ser_dout);

endmodule

bind if_gate_counter if_gate_counter_chk chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_tick(ref_tick),
    .ser_en(ser_en), .ser_dout(ser_dout), .busy(busy), .done(done)
);

// File: tb/if_gate_counter_tb_top.sv
module if_gate_counter_tb_top;
    localparam int W    = 10;
    localparam int CMAX = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic if_pulse = 1'b0, ref_tick = 1'b0, start = 1'b0;
    logic ser_clk = 1'b0, ser_en = 1'b0;
    logic [1:0] period_sel = 2'd0;
    logic ser_dout, busy, done, sat;

    int checks = 0, errors = 0;
    int mode = 0, tick_div = 5, tick_ph = 0, cyc = 0;
    logic [7:0] lfsr = 8'h5a;

    // behavioural reference model state
    int m_busy, m_ticks, m_len, m_cnt, m_accsat, m_close, m_res, m_sat, m_done;
    int m_shift, m_enp, m_sclkp, m_busycyc, dut_busycyc;

    always #2.5 clk = ~clk;

    if_gate_counter #(.CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .if_pulse(if_pulse), .ref_tick(ref_tick),
        .period_sel(period_sel), .start(start), .ser_clk(ser_clk), .ser_en(ser_en),
        .ser_dout(ser_dout), .busy(busy), .done(done), .sat(sat)
    );

    function automatic int blen(input logic [1:0] s);
        case (s)
            2'd0: return 4;
            2'd1: return 8;
            2'd2: return 32;
            default: return 64;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // stimulus for IF pulses and reference ticks
    always @(negedge clk) begin
        cyc++;
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tick_ph = (tick_ph + 1) % tick_div;
        ref_tick <= (tick_ph == 0);
        case (mode)
            1: if_pulse <= 1'b1;
            2: if_pulse <= (cyc % 3 == 0);
            3: if_pulse <= lfsr[0];
            default: if_pulse <= 1'b0;
        endcase
    end

    // reference model
    always @(posedge clk) begin
        int en_rise, sclk_rise, end_now;
        if (!rst_n) begin
            m_busy = 0; m_ticks = 0; m_len = 4; m_cnt = 0; m_accsat = 0; m_close = 0;
            m_res = 0; m_sat = 0; m_done = 0; m_shift = 0; m_enp = 0; m_sclkp = 0;
        end else begin
            en_rise   = (ser_en && !m_enp);
            sclk_rise = (ser_clk && !m_sclkp);
            end_now   = (m_busy && ref_tick && (m_ticks + 1 == m_len));
            if (en_rise) m_shift = m_res;
            else if (ser_en && sclk_rise) m_shift = (m_shift << 1) & CMAX;
            if (en_rise) m_done = 0;
            if (m_close) begin m_res = m_cnt; m_sat = m_accsat; m_done = 1; end
            if (!m_busy && start) begin m_cnt = 0; m_accsat = 0; end
            else if (m_busy && if_pulse) begin
                if (m_cnt == CMAX) m_accsat = 1; else m_cnt++;
            end
            if (m_busy) m_busycyc++;
            if (!m_busy && start) begin
                m_busy = 1; m_ticks = 0; m_len = blen(period_sel); m_busycyc = 0;
            end else if (end_now) begin
                m_busy = 0; m_ticks = 0;
            end else if (m_busy && ref_tick) m_ticks++;
            m_close = end_now;
            m_enp = ser_en; m_sclkp = ser_clk;
        end
    end

    // per-cycle comparison, sampled at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 busy", busy, m_busy);
            chk("R6 done", done, m_done);
            chk("R5 sat", sat, m_sat);
            chk("R7 dout", ser_dout, (ser_en && ((m_shift >> (W - 1)) & 1)) ? 1 : 0);
            if (busy) dut_busycyc++;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog expired, gate never completed");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic launch(input logic [1:0] s);
        period_sel = s;
        start = 1'b1;
        dut_busycyc = 0;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_result();
        for (int i = 0; i < 5000 && !(done && !busy); i++) @(negedge clk);
    endtask

    task automatic read_out(output int v);
        v = 0;
        ser_en = 1'b1;
        @(negedge clk);
        for (int i = 0; i < W; i++) begin
            v = (v << 1) | int'(ser_dout);
            ser_clk = 1'b1;
            @(negedge clk);
            ser_clk = 1'b0;
            @(negedge clk);
        end
        ser_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int v, exp_r;
        repeat (3) @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 sat", sat, 0);
        chk("R1 dout", ser_dout, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", busy, 0);

        // A: every cycle, shortest gate
        mode = 1; tick_div = 5;
        launch(2'd0);
        chk("R2 busy after start", busy, 1);
        wait_result();
        exp_r = m_busycyc;
        read_out(v);
        chk("R4 count equals open cycles", v, exp_r);
        chk("R3 4-tick window length", (dut_busycyc >= 15 && dut_busycyc <= 20) ? 1 : 0, 1);

        // B: no pulses, 8 ticks; pulses outside window ignored
        mode = 0; tick_div = 6;
        launch(2'd1);
        wait_result();
        mode = 1;
        repeat (10) @(negedge clk);
        read_out(v);
        chk("R4 zero count", v, 0);
        mode = 0;

        // C: every third cycle, 32 ticks
        mode = 2; tick_div = 7;
        launch(2'd2);
        wait_result();
        exp_r = m_res;
        read_out(v);
        chk("R3 32-tick result", v, exp_r);

        // D: saturation at 64 ticks
        mode = 1; tick_div = 20;
        launch(2'd3);
        wait_result();
        chk("R5 sat flag", sat, 1);
        read_out(v);
        chk("R5 saturated value", v, CMAX);

        // E: second start and period change while busy are ignored
        mode = 1; tick_div = 5;
        launch(2'd0);
        repeat (6) @(negedge clk);
        launch(2'd3);
        period_sel = 2'd2;
        wait_result();
        chk("R2 restart ignored", (dut_busycyc <= 20) ? 1 : 0, 1);
        chk("R9 period held", (m_busycyc <= 20) ? 1 : 0, 1);
        chk("R5 sat cleared by new start", sat, 0);

        // G: done holds until serial enable rises
        repeat (20) @(negedge clk);
        chk("R6 done held", done, 1);
        ser_en = 1'b1;
        @(negedge clk);
        chk("R6 done cleared on read", done, 0);
        ser_en = 1'b0;
        @(negedge clk);

        // F: readout during open window leaves it undisturbed
        mode = 3; tick_div = 6;
        launch(2'd1);
        read_out(v);
        chk("R8 old result readable while busy", v, m_res);
        wait_result();
        exp_r = m_res;
        read_out(v);
        chk("R8 count after busy readout", v, exp_r);
        chk("R7 MSB-first readout value", v, exp_r);

        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule